// File: doc/BRIEF.md
# Reservation Station Renaming Unit

This block issues arithmetic instructions in program order from a small instruction queue into reservation stations. It executes them out of order as their operands arrive. There are two kinds of station: adder stations (add, subtract) and multiplier stations. Each station owns a fixed-latency execution stub. At issue, a source register that is not awaiting a result is copied into the station as a value. Otherwise the station records the tag of the station that will produce that value. The tag is the station's index.

The destination register's status entry is rewritten with the new station's tag. This renames the register and removes write-after-read and write-after-write conflicts. Finished results go out one per cycle on a single broadcast bus. The bus carries the tag, the destination register and the value. Every waiting station and the register file take the value from this bus. A register read port lets the surrounding logic, or a bench, observe the architectural state.

Top module: `rs_rename_core`

## Requirements
- R1: Instructions enter through a queue of QDEPTH entries. `in_ready` is low exactly when the queue is full. Entries leave the queue strictly in arrival order. A full queue discards nothing.
- R2: When no free station of the head instruction's kind exists, the head stays in the queue unchanged until one is freed. Op codes 2 (multiply) go to multiplier stations. All other codes go to adder stations. Adder stations carry tags 0..N_ADD-1 and multiplier stations carry the tags that follow. The lowest free station of the right kind is taken.
- R3: At issue, the destination register's status becomes "pending" with the new station's tag. Each source that is not pending is copied from the register file.
- R4: A station begins executing only once both operands are values. With no waiting, the result appears on the bus at the clock edge LAT+2 edges after the instruction is accepted. LAT is ADD_LAT for adder stations and MUL_LAT for multiplier stations.
- R5: Op 0 computes src1+src2, op 1 computes src1-src2, op 2 computes src1*src2 and op 3 computes src1+src2, all modulo 2^DW. After all outstanding work has drained, every register holds the value a strictly sequential execution of the program would give.
- R6: A bus result is written to a register only while that register's status still holds the broadcasting tag. A result from an older writer leaves the register untouched.
- R7: At most one result uses the bus per cycle. When several stations have finished, the lowest tag goes first and the others hold their results.
- R8: A source operand whose producer broadcasts in the same cycle as the consumer's issue takes the broadcast value. The consumer does not wait forever.
- R9: A station becomes free in the cycle after its result is broadcast and can be reused from then on.
- R10: After reset, register i holds the value i. No register is pending, the bus is idle and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Queue can accept an instruction |
| in_op | input | 2 | Operation code (0 add, 1 sub, 2 mul, 3 add) |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src1 | input | $clog2(NREG) | First source register |
| in_src2 | input | $clog2(NREG) | Second source register |
| cdb_valid | output | 1 | A result is on the broadcast bus |
| cdb_tag | output | $clog2(N_ADD+N_MUL) | Tag of the broadcasting station |
| cdb_dst | output | $clog2(NREG) | Destination register of the broadcast result |
| cdb_value | output | DW | Broadcast result value |
| rd_addr | input | $clog2(NREG) | Register read address |
| rd_data | output | DW | Register file content at rd_addr |
| rd_busy | output | 1 | Register at rd_addr is awaiting a result |

## Verification
The embedded properties cover the cycle-level rules on every cycle:
- a full queue does not change its fill level except by popping;
- a stalled head stays put;
- issue leaves the destination pending with the right tag;
- execution never starts before both operands are values;
- a station frees one cycle after its broadcast;
- no lower-tagged finished station is passed over on the bus;
- no register changes except through a matching broadcast.

Only the bench scenarios can show the end-to-end behaviour: the computed values, correct sequential semantics under renaming, the exact latency, the bus order under collisions and station reuse, and the same-cycle bypass that keeps a consumer from waiting forever.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam logic [1:0] OP_ADD = 2'd0;
  localparam logic [1:0] OP_SUB = 2'd1;
  localparam logic [1:0] OP_MUL = 2'd2;

  function automatic logic needs_mul(input logic [1:0] op);
    return op == OP_MUL;
  endfunction
endpackage

// File: rtl/rsr_fifo.sv
module rsr_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         can_push,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign can_push   = fill != CW'(DEPTH);
  assign head_valid = fill != '0;
  assign head_data  = mem[rd_ptr];
  assign do_push    = push && can_push;
  assign do_pop     = pop && head_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= wrap_inc(wr_ptr);
      end
      if (do_pop) rd_ptr <= wrap_inc(rd_ptr);
      fill <= fill + CW'(do_push) - CW'(do_pop);
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !can_push) |=> (fill == $past(fill) - CW'($past(do_pop))));
endmodule

// File: rtl/rsr_station.sv
module rsr_station #(
  parameter int DW  = 16,
  parameter int TW  = 3,
  parameter int RW  = 3,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    ld_op,
  input  logic [RW-1:0] ld_dst,
  input  logic [DW-1:0] ld_vj,
  input  logic [DW-1:0] ld_vk,
  input  logic [TW-1:0] ld_qj,
  input  logic [TW-1:0] ld_qk,
  input  logic          ld_qjv,
  input  logic          ld_qkv,
  input  logic          cdb_valid,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_value,
  input  logic          grant,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] res,
  output logic [RW-1:0] dst
);
  import rsr_pkg::*;
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [1:0]    op;
  logic [DW-1:0] vj, vk;
  logic [TW-1:0] qj, qk;
  logic          qjv, qkv, exec, start;
  logic [CW-1:0] cnt;

  function automatic logic [DW-1:0] calc(input logic [1:0] o, input logic [DW-1:0] a,
                                         input logic [DW-1:0] b);
    case (o)
      OP_SUB:  return a - b;
      OP_MUL:  return a * b;
      default: return a + b;
    endcase
  endfunction

  assign start = busy && !qjv && !qkv && !exec && !done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      exec <= 1'b0;
      qjv  <= 1'b0;
      qkv  <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      done <= 1'b0;
      exec <= 1'b0;
      op   <= ld_op;
      dst  <= ld_dst;
      vj   <= ld_vj;
      vk   <= ld_vk;
      qj   <= ld_qj;
      qk   <= ld_qk;
      qjv  <= ld_qjv;
      qkv  <= ld_qkv;
    end else if (busy) begin
      if (done && grant) begin
        busy <= 1'b0;
        done <= 1'b0;
      end
      if (qjv && cdb_valid && qj == cdb_tag) begin
        vj  <= cdb_value;
        qjv <= 1'b0;
      end
      if (qkv && cdb_valid && qk == cdb_tag) begin
        vk  <= cdb_value;
        qkv <= 1'b0;
      end
      if (start) begin
        exec <= 1'b1;
        cnt  <= CW'(LAT - 1);
      end else if (exec) begin
        if (cnt == '0) begin
          exec <= 1'b0;
          done <= 1'b1;
          res  <= calc(op, vj, vk);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R4
  dispatch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec) |-> $past(busy && !qjv && !qkv));
  // R9
  free_after_cdb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && grant) |=> !busy);
endmodule

// File: rtl/rs_rename_core.sv
module rs_rename_core #(
  parameter int DW      = 16,
  parameter int NREG    = 8,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 3,
  parameter int QDEPTH  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [1:0]                        in_op,
  input  logic [$clog2(NREG)-1:0]           in_dst,
  input  logic [$clog2(NREG)-1:0]           in_src1,
  input  logic [$clog2(NREG)-1:0]           in_src2,
  output logic                              cdb_valid,
  output logic [$clog2(N_ADD+N_MUL)-1:0]    cdb_tag,
  output logic [$clog2(NREG)-1:0]           cdb_dst,
  output logic [DW-1:0]                     cdb_value,
  input  logic [$clog2(NREG)-1:0]           rd_addr,
  output logic [DW-1:0]                     rd_data,
  output logic                              rd_busy
);
  import rsr_pkg::*;
  localparam int NRS = N_ADD + N_MUL;
  localparam int RW  = $clog2(NREG);
  localparam int TW  = $clog2(NRS);
  localparam int IW  = 2 + 3 * RW;

  // architectural state and rename table
  logic [DW-1:0] regs       [NREG];
  logic          stat_valid [NREG];
  logic [TW-1:0] stat_tag   [NREG];

  // queue head
  logic          head_valid;
  logic [IW-1:0] head_word;
  logic [1:0]    head_op;
  logic [RW-1:0] head_dst, head_s1, head_s2;
  assign {head_op, head_dst, head_s1, head_s2} = head_word;

  // station signals
  logic [NRS-1:0] st_busy, st_done, load_vec, grant;
  logic [DW-1:0]  st_res [NRS];
  logic [RW-1:0]  st_dst [NRS];

  // issue events
  logic          type_free, issue_fire;
  logic [TW-1:0] new_tag;
  logic [DW-1:0] op_v [2];
  logic [TW-1:0] op_q [2];
  logic          op_qv [2];
  logic [TW-1:0] win_tag;

  rsr_fifo #(.W(IW), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(in_valid), .push_data({in_op, in_dst, in_src1, in_src2}), .can_push(in_ready),
    .pop(issue_fire), .head_valid(head_valid), .head_data(head_word)
  );

  // lowest free station of the head's kind
  always_comb begin
    type_free = 1'b0;
    new_tag   = '0;
    for (int i = NRS - 1; i >= 0; i--) begin
      if (((i >= N_ADD) == needs_mul(head_op)) && !st_busy[i]) begin
        type_free = 1'b1;
        new_tag   = TW'(i);
      end
    end
  end
  assign issue_fire = head_valid && type_free;
  assign load_vec   = issue_fire ? (NRS'(1) << new_tag) : '0;

  // operand resolution: register file, same-cycle broadcast, or producer tag
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      logic [RW-1:0] src;
      src      = (s == 0) ? head_s1 : head_s2;
      op_v[s]  = regs[src];
      op_q[s]  = stat_tag[src];
      op_qv[s] = 1'b0;
      if (stat_valid[src]) begin
        if (cdb_valid && cdb_tag == stat_tag[src]) op_v[s] = cdb_value;
        else op_qv[s] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NRS; i++) begin : g_st
    rsr_station #(.DW(DW), .TW(TW), .RW(RW),
                  .LAT((i < N_ADD) ? ADD_LAT : MUL_LAT)) u_st (
      .clk(clk), .rst_n(rst_n), .load(load_vec[i]),
      .ld_op(head_op), .ld_dst(head_dst),
      .ld_vj(op_v[0]), .ld_vk(op_v[1]), .ld_qj(op_q[0]), .ld_qk(op_q[1]),
      .ld_qjv(op_qv[0]), .ld_qkv(op_qv[1]),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
      .grant(grant[i]), .busy(st_busy[i]), .done(st_done[i]),
      .res(st_res[i]), .dst(st_dst[i])
    );
  end

  // single broadcast bus, lowest finished tag wins
  always_comb begin
    cdb_valid = 1'b0;
    win_tag   = '0;
    for (int i = NRS - 1; i >= 0; i--) begin
      if (st_done[i]) begin
        cdb_valid = 1'b1;
        win_tag   = TW'(i);
      end
    end
  end
  assign grant     = cdb_valid ? (NRS'(1) << win_tag) : '0;
  assign cdb_tag   = win_tag;
  assign cdb_value = st_res[win_tag];
  assign cdb_dst   = st_dst[win_tag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        regs[r]       <= DW'(r);
        stat_valid[r] <= 1'b0;
        stat_tag[r]   <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (cdb_valid && stat_valid[r] && stat_tag[r] == cdb_tag) begin
          regs[r]       <= cdb_value;
          stat_valid[r] <= 1'b0;
        end
        if (issue_fire && head_dst == RW'(r)) begin
          stat_valid[r] <= 1'b1;
          stat_tag[r]   <= new_tag;
        end
      end
    end
  end

  assign rd_data = regs[rd_addr];
  assign rd_busy = stat_valid[rd_addr];

  // R2
  issue_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && !type_free) |=> (head_valid && $stable(head_word)));
  // R3
  status_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> (stat_valid[$past(head_dst)] && stat_tag[$past(head_dst)] == $past(new_tag)));

  for (genvar j = 0; j < NRS; j++) begin : g_prio
    // R7
    cdb_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && int'(cdb_tag) > j) |-> !st_done[j]);
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    // R6
    stale_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cdb_valid && stat_valid[r] && stat_tag[r] == cdb_tag) |=> $stable(regs[r]));
  end
endmodule

// File: tb/sim_rs_rename_core.sv
module sim_rs_rename_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic [2:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic        cdb_valid;
  logic [2:0]  cdb_tag, cdb_dst;
  logic [15:0] cdb_value;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_busy;

  int checks = 0;
  int failures = 0;
  logic [15:0] mreg [8];
  bit saw_full = 0;

  typedef struct { int dst; logic [15:0] val; } exp_t;
  exp_t expq [$];
  int   tag_log [$];

  always #4 clk = ~clk;

  rs_rename_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_dst(cdb_dst), .cdb_value(cdb_value),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_busy(rd_busy)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [31:0] p;
    if (op == 2'd1) return a - b;
    if (op == 2'd2) begin p = a * b; return p[15:0]; end
    return a + b;
  endfunction

  // driver: computes the sequential result, queues it, offers the instruction
  task automatic push(input int op, input int d, input int a, input int b);
    exp_t e;
    e.dst = d;
    e.val = model_op(2'(op), mreg[a], mreg[b]);
    mreg[d] = e.val;
    expq.push_back(e);
    @(negedge clk);
    while (!in_ready) begin saw_full = 1; @(negedge clk); end
    in_valid = 1'b1; in_op = 2'(op); in_dst = 3'(d); in_src1 = 3'(a); in_src2 = 3'(b);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor: every broadcast must match an outstanding expected result
  always @(negedge clk) begin
    if (rst_n && cdb_valid) begin
      int hit;
      hit = -1;
      tag_log.push_back(int'(cdb_tag));
      foreach (expq[k]) if (hit < 0 && expq[k].dst == int'(cdb_dst) && expq[k].val == cdb_value) hit = k;
      check(hit >= 0, "R5", "unexpected broadcast value", int'(cdb_value), -1);
      if (hit >= 0) expq.delete(hit);
    end
  end

  task automatic drain(input string req);
    int n = 0;
    while (expq.size() != 0 && n < 400) begin @(negedge clk); n++; end
    check(expq.size() == 0, req, "results still outstanding", expq.size(), 0);
    expq.delete();
    repeat (3) @(negedge clk);
    for (int r = 0; r < 8; r++) begin
      rd_addr = 3'(r);
      #1;
      check(rd_busy == 1'b0, req, $sformatf("reg %0d pending", r), int'(rd_busy), 0);
      check(rd_data == mreg[r], req, $sformatf("reg %0d value", r), int'(rd_data), int'(mreg[r]));
    end
  endtask

  task automatic latency(input int op, input int expect_n, input string req);
    int n = 0;
    push(op, 4, 2, 3);
    @(negedge clk);
    while (!cdb_valid && n < 30) begin @(negedge clk); n++; end
    check(n == expect_n, req, "cycles to broadcast", n, expect_n);
    drain(req);
  endtask

  task automatic check_log(input int exp_tags [$], input string req);
    check(tag_log.size() == exp_tags.size(), req, "broadcast count", tag_log.size(), exp_tags.size());
    foreach (exp_tags[k])
      if (k < tag_log.size())
        check(tag_log[k] == exp_tags[k], req, $sformatf("broadcast %0d tag", k), tag_log[k], exp_tags[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) mreg[r] = 16'(r);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(in_ready == 1'b1, "R10", "in_ready after reset", int'(in_ready), 1);
    check(cdb_valid == 1'b0, "R10", "bus idle after reset", int'(cdb_valid), 0);
    for (int r = 0; r < 8; r++) begin
      rd_addr = 3'(r);
      #1;
      check(rd_data == 16'(r) && !rd_busy, "R10", $sformatf("reg %0d reset", r), int'(rd_data), r);
    end

    // R4 fixed latency per station kind
    latency(0, 4, "R4");
    latency(2, 5, "R4");

    // R7 add and multiply finish in the same cycle: lowest tag first
    tag_log.delete();
    push(2, 5, 2, 3);
    push(0, 6, 3, 3);
    drain("R7");
    check_log('{0, 3}, "R7");

    // R2 and R9: three adders wait on a multiply, a fourth add reuses station 0
    tag_log.delete();
    push(2, 1, 2, 3);
    push(0, 4, 1, 0);
    push(0, 5, 1, 1);
    push(1, 6, 1, 2);
    push(0, 7, 2, 3);
    drain("R2");
    check_log('{3, 0, 1, 2, 0}, "R9");

    // R8 consumer issued at several distances from its producer's broadcast
    for (int gap = 0; gap < 8; gap++) begin
      push(2, 1, 1, 2);
      repeat (gap) @(negedge clk);
      push(0, 3, 1, 4);
      drain("R8");
    end

    // R6 / R3 renaming through WAW and WAR
    push(2, 1, 2, 3);
    push(0, 1, 4, 5);
    push(1, 4, 1, 2);
    push(0, 2, 6, 6);
    push(2, 6, 2, 1);
    drain("R6");

    // R1 burst of dependent multiplies fills the queue
    saw_full = 0;
    for (int k = 0; k < 8; k++) push(2, 1, 1, 3);
    check(saw_full, "R1", "queue reported full", int'(saw_full), 1);
    drain("R1");

    // R5 mixed pseudo-random program
    begin
      int seed = 17;
      for (int k = 0; k < 48; k++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        push((seed >> 4) & 3, (seed >> 8) & 7, (seed >> 12) & 7, (seed >> 16) & 7);
      end
    end
    drain("R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule